// File: doc/BRIEF.md
# Interrupt Status Collector with Read-to-Clear Sources

This block gathers the twelve event sources of a two-wire serial bus controller into a raw status word, gates that word with a programmable enable mask, and raises a single interrupt line whenever any enabled source is pending. Ten sources are sticky: a one-cycle event pulse sets them and they stay set until software clears them. The receive-full and transmit-empty sources are level signals taken straight from the FIFO conditions.

Software clears a sticky source by reading that source's own clear address. Events that arrive between a status read and the clear are therefore never lost, because each clear touches only the one bit that was read. A combined clear address drops every sticky source at once. When the controller reports a transfer abort, the block sets the tx-abort source and ORs the reason bits into an abort-reason word. That word is emptied only by a read of the tx-abort clear address.

Register reads go through a two-state access sequencer. In state ACC_IDLE a read request moves it to ACC_RESP, and the data and valid flag are presented in the next cycle. In ACC_RESP a further request keeps it in ACC_RESP (back-to-back reads); with no request it returns to ACC_IDLE. The mask register is written in a single cycle.

Top module: `irq_ctrl_unit`

## Requirements
- R1: After reset the sticky status bits, the mask, the abort reason, `irq_o` and `rd_valid_o` are all 0.
- R2: A pulse on `evt_i[k]` sets sticky status bit k, and the bit stays set until it is cleared. Bit meanings: 0 rx underflow, 1 rx overflow, 3 tx overflow, 5 read request, 6 tx abort, 7 rx done, 8 activity, 9 stop seen, 10 start seen, 11 general call. Raw status is read at address 0x00.
- R3: The masked status read at address 0x01 equals the raw status ANDed with the mask.
- R4: `irq_o` is the OR of all masked status bits, registered, so it follows one cycle after the status changes.
- R5: Reading address 0x10+k, for a sticky source k, clears only bit k and returns that bit's previous value in data bit 0.
- R6: Reading address 0x08 returns the full raw status and clears every sticky bit. It leaves the abort reason unchanged.
- R7: When a set pulse and a clear of the same bit occur in the same cycle, the set wins and the bit reads 1 afterwards.
- R8: Bit 2 follows `rx_full_i` and bit 4 follows `tx_empty_i` directly. Pulses on `evt_i[2]` and `evt_i[4]` and all clear reads leave these two bits unaffected, and reads of 0x12 and 0x14 return 0.
- R9: A nonzero `abort_i` (bits 6 and 8 ignored) sets status bit 6 and ORs its bits into the abort reason. Reason bits 6 and 8 always read 0. The reason is read at address 0x03.
- R10: The abort reason is cleared only by a read of address 0x16. Nothing else removes a reason bit.
- R11: `rd_valid_o` is 1 exactly in the cycle after a cycle with `rd_en_i` high, and `rd_data_o` then holds the addressed value.
- R12: A write to address 0x02 loads the mask from `wr_data_i[11:0]`, and the mask reads back at 0x02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 12 | One-cycle event pulses, one per status bit |
| rx_full_i | input | 1 | Receive FIFO at threshold (level) |
| tx_empty_i | input | 1 | Transmit FIFO at threshold (level) |
| abort_i | input | 13 | Abort reason pulses from the controller |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 5 | Register read address |
| rd_data_o | output | 16 | Read data, valid with rd_valid_o |
| rd_valid_o | output | 1 | Read response strobe |
| irq_o | output | 1 | Interrupt request |

## Verification
A sticky bit that is wrongly held or lost shows at the ports within one cycle as a wrong `irq_o` level with the mask open. It also shows on the next raw-status read, so the bench reads status after every set and clear sequence. A clear decoder that hits a neighbouring bit shows up when all sources are set, one is cleared, and the raw word is read back. A lost or extra abort-reason bit stays hidden until address 0x03 is read, so that read follows every abort pulse and every clear.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_SRC = 12;
    localparam int ABORT_W = 13;
    localparam int ADDR_W  = 5;

    // status bit positions that the clear decoder and abort path rely on
    localparam int SRC_RX_FULL  = 2;
    localparam int SRC_TX_EMPTY = 4;
    localparam int SRC_TX_ABRT  = 6;

    // sticky sources: every bit except the two level-driven ones
    localparam logic [NUM_SRC-1:0] LATCH_MASK  = 12'hFEB;
    // abort reason bits that carry meaning (6 and 8 reserved)
    localparam logic [ABORT_W-1:0] ABORT_VALID = 13'h1EBF;

    localparam logic [ADDR_W-1:0] A_RAW       = 5'h00;
    localparam logic [ADDR_W-1:0] A_MASKED    = 5'h01;
    localparam logic [ADDR_W-1:0] A_MASK      = 5'h02;
    localparam logic [ADDR_W-1:0] A_ABORT     = 5'h03;
    localparam logic [ADDR_W-1:0] A_CLR_ALL   = 5'h08;
    localparam logic [ADDR_W-1:0] A_CLR_BASE  = 5'h10;
    localparam logic [ADDR_W-1:0] A_CLR_TXABRT = A_CLR_BASE + ADDR_W'(SRC_TX_ABRT);

    typedef enum logic {
        ACC_IDLE = 1'b0,
        ACC_RESP = 1'b1
    } acc_state_e;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
    import irq_pkg::*;
#(
    parameter int                  N       = NUM_SRC,
    parameter logic [NUM_SRC-1:0]  LATCHED = LATCH_MASK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] raw_o
);
    for (genvar k = 0; k < N; k++) begin : g_src
        if (LATCHED[k]) begin : g_sticky
            logic q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= 1'b0;
                else
                    q <= set_i[k] | (q & ~clr_i[k]);   // set wins over clear
            end
            assign raw_o[k] = q;
            logic unused_lvl;
            assign unused_lvl = lvl_i[k];
        end else begin : g_level
            assign raw_o[k] = lvl_i[k];
            logic unused_sc;
            assign unused_sc = set_i[k] ^ clr_i[k];
        end
    end
endmodule

// File: rtl/irq_abort_reason.sv
module irq_abort_reason
    import irq_pkg::*;
#(
    parameter int               W     = ABORT_W,
    parameter logic [W-1:0]     VALID = ABORT_VALID
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] abort_i,
    input  logic         clr_i,
    output logic [W-1:0] reason_o,
    output logic         event_o
);
    logic [W-1:0] reason_q;
    logic [W-1:0] incoming;

    assign incoming = abort_i & VALID;
    assign event_o  = |incoming;

    always_ff @(posedge clk) begin
        if (!rst_n)
            reason_q <= '0;
        else
            reason_q <= (reason_q & ~{W{clr_i}}) | incoming;
    end

    assign reason_o = reason_q;
endmodule

// File: rtl/irq_access_fsm.sv
module irq_access_fsm
    import irq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic [NUM_SRC-1:0] raw_i,
    input  logic [NUM_SRC-1:0] masked_i,
    input  logic [ABORT_W-1:0] reason_i,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [NUM_SRC-1:0] clr_src_o,
    output logic               clr_reason_o,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic               rd_valid_o
);
    acc_state_e          state_q, state_d;
    logic [NUM_SRC-1:0]  mask_q;
    logic [DATA_W-1:0]   rd_word;
    logic [DATA_W-1:0]   rd_data_q;

    logic unused_wr;
    assign unused_wr = ^wr_data_i[DATA_W-1:NUM_SRC];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ACC_IDLE;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: if (rd_en_i)  state_d = ACC_RESP;
            ACC_RESP: if (!rd_en_i) state_d = ACC_IDLE;
            default:                state_d = ACC_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_valid_o = (state_q == ACC_RESP);
        rd_data_o  = rd_data_q;
    end

    // read word selection
    always_comb begin
        rd_word = '0;
        if (rd_addr_i == A_RAW)
            rd_word[NUM_SRC-1:0] = raw_i;
        else if (rd_addr_i == A_MASKED)
            rd_word[NUM_SRC-1:0] = masked_i;
        else if (rd_addr_i == A_MASK)
            rd_word[NUM_SRC-1:0] = mask_q;
        else if (rd_addr_i == A_ABORT)
            rd_word[ABORT_W-1:0] = reason_i;
        else if (rd_addr_i == A_CLR_ALL)
            rd_word[NUM_SRC-1:0] = raw_i;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (LATCH_MASK[k] && rd_addr_i == (A_CLR_BASE + ADDR_W'(k)))
                rd_word[0] = raw_i[k];
        end
    end

    // clear decoding: side effect of the read strobe
    always_comb begin
        clr_src_o = '0;
        if (rd_en_i && rd_addr_i == A_CLR_ALL)
            clr_src_o = LATCH_MASK;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (rd_en_i && LATCH_MASK[k] && rd_addr_i == (A_CLR_BASE + ADDR_W'(k)))
                clr_src_o[k] = 1'b1;
        end
        clr_reason_o = rd_en_i && (rd_addr_i == A_CLR_TXABRT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q <= '0;
            mask_q    <= '0;
        end else begin
            if (rd_en_i)
                rd_data_q <= rd_word;
            if (wr_en_i && wr_addr_i == A_MASK)
                mask_q <= wr_data_i[NUM_SRC-1:0];
        end
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit
    import irq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               rx_full_i,
    input  logic               tx_empty_i,
    input  logic [ABORT_W-1:0] abort_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic               rd_en_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic               rd_valid_o,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] raw_status;
    logic [NUM_SRC-1:0] masked_status;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] clr_src;
    logic [NUM_SRC-1:0] set_src;
    logic [NUM_SRC-1:0] lvl_src;
    logic [ABORT_W-1:0] abort_reason;
    logic               clr_reason;
    logic               abort_evt;
    logic               irq_q;

    always_comb begin
        lvl_src               = '0;
        lvl_src[SRC_RX_FULL]  = rx_full_i;
        lvl_src[SRC_TX_EMPTY] = tx_empty_i;
        set_src               = evt_i;
        set_src[SRC_TX_ABRT]  = evt_i[SRC_TX_ABRT] | abort_evt;
    end

    irq_src_bank #(.N(NUM_SRC), .LATCHED(LATCH_MASK)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_src),
        .clr_i (clr_src),
        .lvl_i (lvl_src),
        .raw_o (raw_status)
    );

    irq_abort_reason #(.W(ABORT_W), .VALID(ABORT_VALID)) u_reason (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort_i  (abort_i),
        .clr_i    (clr_reason),
        .reason_o (abort_reason),
        .event_o  (abort_evt)
    );

    assign masked_status = raw_status & mask_q;

    irq_access_fsm #(.DATA_W(DATA_W)) u_acc (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_en_i      (rd_en_i),
        .rd_addr_i    (rd_addr_i),
        .wr_en_i      (wr_en_i),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i),
        .raw_i        (raw_status),
        .masked_i     (masked_status),
        .reason_i     (abort_reason),
        .mask_o       (mask_q),
        .clr_src_o    (clr_src),
        .clr_reason_o (clr_reason),
        .rd_data_o    (rd_data_o),
        .rd_valid_o   (rd_valid_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= |masked_status;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
    import irq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] evt_i,
    input logic [ABORT_W-1:0] abort_i,
    input logic               rd_en_i,
    input logic [ADDR_W-1:0]  rd_addr_i,
    input logic [NUM_SRC-1:0] raw_i,
    input logic [NUM_SRC-1:0] mask_i,
    input logic [ABORT_W-1:0] reason_i,
    input logic               irq_i,
    input logic               rd_valid_i
);
    // R2 / R7: a pulsed sticky bit is set after the edge, even under a clear
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_i & LATCH_MASK)) |=>
        ((raw_i & $past(evt_i & LATCH_MASK)) == $past(evt_i & LATCH_MASK)));

    // R4: interrupt follows the masked status one cycle later
    a_r4_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (|(raw_i & mask_i)) |=> irq_i);
    a_r4_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(raw_i & mask_i)) |=> !irq_i);

    // R5: clearing the stop source leaves every other sticky bit alone
    a_r5_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_addr_i == (A_CLR_BASE + 5'd9) && evt_i == '0 && abort_i == '0) |=>
        (((raw_i ^ $past(raw_i)) & LATCH_MASK & ~12'h200) == '0));

    // R9: reserved reason bits never set
    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reason_i[6] == 1'b0) && (reason_i[8] == 1'b0));

    // R10: without a tx-abort clear read no reason bit is dropped
    a_r10_reason_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en_i && rd_addr_i == A_CLR_TXABRT) |=>
        ((reason_i & $past(reason_i)) == $past(reason_i)));

    // R11: read response strobe timing
    a_r11_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rd_valid_i);
    a_r11_valid_clr: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> !rd_valid_i);
endmodule

bind irq_ctrl_unit irq_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .abort_i    (abort_i),
    .rd_en_i    (rd_en_i),
    .rd_addr_i  (rd_addr_i),
    .raw_i      (raw_status),
    .mask_i     (mask_q),
    .reason_i   (abort_reason),
    .irq_i      (irq_o),
    .rd_valid_i (rd_valid_o)
);

// File: tb/sim_irq_ctrl_unit.sv
`timescale 1ns/1ps
module sim_irq_ctrl_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] evt_i = '0;
    logic        rx_full_i = 1'b0;
    logic        tx_empty_i = 1'b0;
    logic [12:0] abort_i = '0;
    logic        wr_en_i = 1'b0;
    logic [4:0]  wr_addr_i = '0;
    logic [15:0] wr_data_i = '0;
    logic        rd_en_i = 1'b0;
    logic [4:0]  rd_addr_i = '0;
    logic [15:0] rd_data_o;
    logic        rd_valid_o;
    logic        irq_o;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    irq_ctrl_unit u0 (.*);

    // evt | mask | read address | expected read data
    localparam logic [44:0] VEC [0:8] = '{
        {12'h001, 12'hFFF, 5'h00, 16'h0001},
        {12'h002, 12'h002, 5'h01, 16'h0002},
        {12'h0A0, 12'h020, 5'h01, 16'h0020},
        {12'hF00, 12'h000, 5'h00, 16'h0F00},
        {12'h808, 12'h800, 5'h01, 16'h0800},
        {12'h014, 12'hFFF, 5'h00, 16'h0000},
        {12'h041, 12'h041, 5'h11, 16'h0000},
        {12'h300, 12'h000, 5'h19, 16'h0001},
        {12'h000, 12'h5A5, 5'h02, 16'h05A5}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk); rd_en_i = 1'b1; rd_addr_i = a;
        @(negedge clk); rd_en_i = 1'b0; d = rd_data_o;
    endtask

    task automatic wr_mask(input logic [11:0] m);
        @(negedge clk); wr_en_i = 1'b1; wr_addr_i = 5'h02; wr_data_i = {4'h0, m};
        @(negedge clk); wr_en_i = 1'b0;
    endtask

    task automatic pulse(input logic [11:0] e);
        @(negedge clk); evt_i = e;
        @(negedge clk); evt_i = '0;
    endtask

    task automatic pulse_abort(input logic [12:0] a);
        @(negedge clk); abort_i = a;
        @(negedge clk); abort_i = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", {15'h0, irq_o}, 16'h0);
        chk("R1 rd_valid", {15'h0, rd_valid_o}, 16'h0);
        rd(5'h00, d); chk("R1 raw", d, 16'h0000);
        rd(5'h02, d); chk("R1 mask", d, 16'h0000);
        rd(5'h03, d); chk("R1 reason", d, 16'h0000);

        // table: R2 R3 R5 R8 R12, plus R4 interrupt latency
        foreach (VEC[i]) begin
            logic [11:0] ev, mk;
            ev = VEC[i][44:33];
            mk = VEC[i][32:21];
            rd(5'h08, d);
            repeat (2) @(negedge clk);
            wr_mask(mk);
            pulse(ev);
            chk("R4 irq before", {15'h0, irq_o}, 16'h0);
            @(negedge clk);
            chk("R4 irq after", {15'h0, irq_o}, {15'h0, |(ev & 12'hFEB & mk)});
            rd(VEC[i][20:16], d);
            chk("R2/R3 table", d, VEC[i][15:0]);
        end

        // R5 single-source clear
        rd(5'h08, d);
        wr_mask(12'h000);
        pulse(12'hFEB);
        rd(5'h19, d); chk("R5 clear returns old", d, 16'h0001);
        rd(5'h00, d); chk("R5 others kept", d, 16'h0DEB);
        rd(5'h19, d); chk("R5 second clear", d, 16'h0000);

        // R6 combined clear
        rd(5'h08, d); chk("R6 returns raw", d, 16'h0DEB);
        rd(5'h00, d); chk("R6 all cleared", d, 16'h0000);

        // R8 level sources
        @(negedge clk); rx_full_i = 1'b1; tx_empty_i = 1'b1;
        rd(5'h00, d); chk("R8 levels", d, 16'h0014);
        rd(5'h12, d); chk("R8 clr rx_full addr", d, 16'h0000);
        rd(5'h08, d); chk("R8 clear all", d, 16'h0014);
        rd(5'h00, d); chk("R8 levels kept", d, 16'h0014);
        @(negedge clk); rx_full_i = 1'b0; tx_empty_i = 1'b0;
        rd(5'h00, d); chk("R8 levels drop", d, 16'h0000);

        // R7 set and clear in the same cycle
        @(negedge clk); evt_i = 12'h200; rd_en_i = 1'b1; rd_addr_i = 5'h19;
        @(negedge clk); evt_i = '0; rd_en_i = 1'b0; d = rd_data_o;
        chk("R7 read old", d, 16'h0000);
        rd(5'h00, d); chk("R7 set wins", d, 16'h0200);

        // R11 response strobe
        @(negedge clk); rd_en_i = 1'b1; rd_addr_i = 5'h02;
        @(negedge clk); rd_en_i = 1'b0;
        chk("R11 valid", {15'h0, rd_valid_o}, 16'h0001);
        @(negedge clk);
        chk("R11 valid drop", {15'h0, rd_valid_o}, 16'h0000);

        // R9 abort reason accumulation
        rd(5'h08, d);
        pulse_abort(13'h0009);
        pulse_abort(13'h1000);
        rd(5'h03, d); chk("R9 accumulate", d, 16'h1009);
        rd(5'h00, d); chk("R9 sets tx abort", d, 16'h0040);
        rd(5'h08, d);
        rd(5'h03, d); chk("R10 kept by clear all", d, 16'h1009);
        pulse_abort(13'h0140);
        rd(5'h00, d); chk("R9 reserved no event", d, 16'h0000);
        pulse_abort(13'h1FFF);
        rd(5'h03, d); chk("R9 reserved zero", d, 16'h1EBF);

        // R10 tx-abort clear
        rd(5'h19, d);
        rd(5'h03, d); chk("R10 other clear keeps", d, 16'h1EBF);
        rd(5'h16, d); chk("R10 clear returns bit", d, 16'h0001);
        rd(5'h03, d); chk("R10 reason cleared", d, 16'h0000);
        rd(5'h00, d); chk("R10 bit6 cleared", d, 16'h0000);

        // R4 interrupt falls after clear
        wr_mask(12'h008);
        pulse(12'h008);
        @(negedge clk);
        chk("R4 irq high", {15'h0, irq_o}, 16'h0001);
        rd(5'h13, d);
        chk("R4 irq still high", {15'h0, irq_o}, 16'h0001);
        @(negedge clk);
        chk("R4 irq falls", {15'h0, irq_o}, 16'h0000);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule